// File: doc/BRIEF.md
# Stereo Multiplex Timing Generator

This block derives every timing square wave that a switched stereo FM multiplexer needs from a single 4.332 MHz master clock. A prescaler divides the clock by 19 to give a 228 kHz step pulse. A six-phase sequencer advances once per step and produces a 38 kHz subcarrier square and a second copy of it that lags by exactly one step, which is 60 degrees. Because the lag is a counted number of steps and not an analog delay, it does not drift with temperature or supply.

From the same step pulse the block also produces a 19 kHz pilot square and a 57 kHz data-carrier square. The pilot toggles on each rising edge of the subcarrier, so it stays phase-locked to it. It also produces two 2-bit channel weights. The left weight is the sum of the two subcarrier squares (0, 1 or 2) and approximates 1+M. The right weight is its complement 2−left, which approximates 1−M and equals the left weight shifted by half a subcarrier period. These weights drive the external audio switch network.

The asynchronous active-low reset is released through a two-flop synchronizer.

Top module: `stereo_timing_gen`

## Requirements
- R1: While rst_n is low, all outputs are forced at once, without waiting for a clock edge, to: sub_sq=1, sub_dly=0, pilot_sq=0, rds_sq=0, left_wt=1, right_wt=1.
- R2: After rst_n rises, the outputs hold their reset values for two clock edges. The third edge is the first counting edge.
- R3: A step occurs every 19 counting edges. The phase index starts at 0 and advances by one per step through 0..5, then wraps to 0. The first phase change follows counting edge 19.
- R4: sub_sq is 1 in phases 0, 1 and 2 and 0 in phases 3, 4 and 5, which gives a period of 114 clocks (38 kHz at 4.332 MHz).
- R5: sub_dly is 1 in phases 1, 2 and 3 and 0 otherwise, so it is sub_sq delayed by one step (19 clocks, 60 degrees).
- R6: pilot_sq toggles exactly when sub_sq rises (the wrap from phase 5 to phase 0) and at no other time, which gives a period of 228 clocks (19 kHz).
- R7: rds_sq toggles after every second step, which gives a period of 76 clocks (57 kHz). Neither rds_sq nor pilot_sq changes on a cycle without a step.
- R8: left_wt is the unsigned 2-bit value sub_sq + sub_dly. By phase 0..5 this is 1,2,2,1,0,0, so it never steps directly between 0 and 2.
- R9: right_wt equals 2 − left_wt (1,0,0,1,2,2 by phase 0..5), which is left_wt shifted by three phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.332 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_sq | output | 1 | 38 kHz subcarrier square |
| sub_dly | output | 1 | Subcarrier square delayed by 60 degrees |
| pilot_sq | output | 1 | 19 kHz pilot square, locked to sub_sq |
| rds_sq | output | 1 | 57 kHz data-carrier square |
| left_wt | output | 2 | Left channel weight, 0..2 |
| right_wt | output | 2 | Right channel weight, 0..2 |

## Verification
On every cycle, the embedded assertions check the following. The prescaler count and the phase index stay in range. The lagging square rises only while the main square is already high. The pilot changes if and only if the main square rises. Both carrier dividers hold still between steps. The left weight never jumps from 2 to 0.

Only the bench scenarios can show the absolute timing: the two-edge delay before counting starts, the exact 19-clock step, the 114, 228 and 76 clock periods counted from reset release, and the asynchronous clear taking effect in the middle of a cycle. The bench shows these by comparing every output on every cycle against a model indexed by the number of edges since release, across runs of random length and resets asserted at random points.

// File: rtl/stereo_timing_pkg.sv
package stereo_timing_pkg;
  localparam int unsigned DEF_PRESCALE  = 19;  // master clocks per step
  localparam int unsigned DEF_PHASES    = 6;   // steps per subcarrier period
  localparam int unsigned DEF_RDS_STEPS = 2;   // steps per data-carrier half period
  typedef logic [1:0] weight_t;
endpackage

// File: rtl/st_reset_sync.sv
module st_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_int_n = sync_q;
endmodule

// File: rtl/st_step_prescaler.sv
module st_step_prescaler #(
  parameter int unsigned DIV = 19
) (
  input  logic clk,
  input  logic rst_n,
  output logic step_en
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    step_en = (cnt_q == LAST);
    cnt_d   = step_en ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/st_phase_seq.sv
module st_phase_seq
  import stereo_timing_pkg::*;
#(
  parameter int unsigned PHASES = 6
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    step_en,
  output logic    sub_sq,
  output logic    sub_dly,
  output logic    wrap,
  output weight_t left_wt,
  output weight_t right_wt
);
  localparam int unsigned SW   = $clog2(PHASES);
  localparam int unsigned HALF = PHASES / 2;
  localparam int unsigned LAG  = PHASES / 6;  // 60 degrees in steps
  localparam logic [SW-1:0] LAST = SW'(PHASES - 1);

  logic [SW-1:0] ph_q, ph_d;

  always_comb begin
    wrap = (ph_q == LAST);
    ph_d = ph_q;
    if (step_en) ph_d = wrap ? '0 : ph_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  always_comb begin
    sub_sq   = (ph_q < SW'(HALF));
    sub_dly  = (ph_q >= SW'(LAG)) && (ph_q < SW'(HALF + LAG));
    left_wt  = {1'b0, sub_sq} + {1'b0, sub_dly};
    right_wt = 2'd2 - left_wt;
  end

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= LAST);
  assert_dly_lags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sub_dly) |-> (sub_sq && $past(sub_sq)));
  assert_no_weight_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (left_wt == 2'd2) |=> (left_wt != 2'd0));
endmodule

// File: rtl/st_toggle_div.sv
module st_toggle_div #(
  parameter int unsigned TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic q
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          q_q, q_d;

  always_comb begin
    cnt_d = cnt_q;
    q_d   = q_q;
    if (en) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        q_d   = ~q_q;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  assign q = q_q;

  assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/stereo_timing_gen.sv
module stereo_timing_gen
  import stereo_timing_pkg::*;
#(
  parameter int unsigned PRESCALE  = DEF_PRESCALE,
  parameter int unsigned PHASES    = DEF_PHASES,
  parameter int unsigned RDS_STEPS = DEF_RDS_STEPS
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       sub_sq,
  output logic       sub_dly,
  output logic       pilot_sq,
  output logic       rds_sq,
  output logic [1:0] left_wt,
  output logic [1:0] right_wt
);
  logic rst_int_n;
  logic step_en;
  logic wrap;
  logic pilot_en;

  st_reset_sync i_rsync (.clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n));

  st_step_prescaler #(.DIV(PRESCALE)) i_pre (
    .clk(clk), .rst_n(rst_int_n), .step_en(step_en));

  st_phase_seq #(.PHASES(PHASES)) i_seq (
    .clk(clk), .rst_n(rst_int_n), .step_en(step_en),
    .sub_sq(sub_sq), .sub_dly(sub_dly), .wrap(wrap),
    .left_wt(left_wt), .right_wt(right_wt));

  // pilot: one toggle per subcarrier rising edge (wrap 5 -> 0)
  assign pilot_en = step_en & wrap;

  st_toggle_div #(.TICKS(1)) i_pilot (
    .clk(clk), .rst_n(rst_int_n), .en(pilot_en), .q(pilot_sq));

  st_toggle_div #(.TICKS(RDS_STEPS)) i_rds (
    .clk(clk), .rst_n(rst_int_n), .en(step_en), .q(rds_sq));

  assert_pilot_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sub_sq) |-> (pilot_sq != $past(pilot_sq)));
  assert_pilot_quiet_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$rose(sub_sq) |-> $stable(pilot_sq));
endmodule

// File: tb/test_stereo_timing_gen.sv
module test_stereo_timing_gen;
  logic       clk;
  logic       rst_n;
  logic       sub_sq, sub_dly, pilot_sq, rds_sq;
  logic [1:0] left_wt, right_wt;

  int checks = 0;
  int errors = 0;
  int n_rel  = 0;   // edges since reset release
  bit done   = 0;

  stereo_timing_gen i_stereo_timing_gen (
    .clk(clk), .rst_n(rst_n), .sub_sq(sub_sq), .sub_dly(sub_dly),
    .pilot_sq(pilot_sq), .rds_sq(rds_sq), .left_wt(left_wt), .right_wt(right_wt));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int step_of(int n);
    return (n > 2) ? (n - 2) / 19 : 0;
  endfunction
  function automatic int e_main(int s);  return ((s % 6) < 3) ? 1 : 0; endfunction
  function automatic int e_dly(int s);   return ((s % 6) >= 1 && (s % 6) <= 3) ? 1 : 0; endfunction
  function automatic int e_pilot(int s); return (s / 6) % 2; endfunction
  function automatic int e_rds(int s);   return (s / 2) % 2; endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at edge %0d", tag, act, exp, n_rel);
    end
  endtask

  task automatic check_all(string rtag);
    int s = step_of(n_rel);
    int l = e_main(s) + e_dly(s);
    chk({rtag, " R4 sub_sq"},   int'(sub_sq),   e_main(s));
    chk({rtag, " R5 sub_dly"},  int'(sub_dly),  e_dly(s));
    chk({rtag, " R6 pilot_sq"}, int'(pilot_sq), e_pilot(s));
    chk({rtag, " R7 rds_sq"},   int'(rds_sq),   e_rds(s));
    chk({rtag, " R8 left_wt"},  int'(left_wt),  l);
    chk({rtag, " R9 right_wt"}, int'(right_wt), 2 - l);
  endtask

  task automatic cycle(string rtag);
    @(posedge clk);
    if (rst_n) n_rel++;
    @(negedge clk);
    check_all(rtag);
  endtask

  task automatic do_reset(int hold);
    rst_n = 1'b0;
    n_rel = 0;
    #1;
    check_all("R1 async");   // forced before any edge
    for (int i = 0; i < hold; i++) cycle("R1 hold");
    rst_n = 1'b1;
    n_rel = 0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    #1;
    check_all("R1 power-up");
    @(negedge clk);
    do_reset(3);
    // R2: two edges still in reset state, then counting
    cycle("R2 edge1");
    cycle("R2 edge2");
    // R3: phase changes only after counting edge 19 (edge 21 after release)
    for (int i = 3; i <= 20; i++) cycle("R3 step0");
    chk("R3 no step yet", int'(sub_dly), 0);
    cycle("R3 first step");
    chk("R3 step at 19", int'(sub_dly), 1);
    // long directed run over several pilot periods
    for (int i = 0; i < 1200; i++) cycle("R6 long");
    // random run lengths with random resets in between
    for (int it = 0; it < 40; it++) begin
      int len  = $urandom_range(3000, 20);
      int hold = $urandom_range(5, 1);
      for (int i = 0; i < len; i++) cycle("R3 rnd");
      #($urandom_range(3, 1));
      do_reset(hold);
    end
    for (int i = 0; i < 300; i++) cycle("R7 tail");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule